// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Direction Control

This block is the parallel I/O port of a small microcontroller. The port is eight bits wide, and six of those bits are backed by pads. Each implemented pin has an output data latch and a direction bit. A direction bit of 1 turns the pad driver off. A direction bit of 0 drives the latch onto the pad. The processor writes the latch through a data port. It loads the direction bits through a separate strobe that carries the accumulator value. One pin, bit 3, can only be an input.

A port read returns the levels on the pads, not the contents of the latch, and pins that have been given to an alternate function read as zero. Single-bit set and clear operations are therefore done by reading the pins, changing one bit and writing all the bits back. This can overwrite the latch of a pin that is currently an input.

One shared enable turns on the weak pull-ups and wake-on-change for bits 0, 1 and 3. When bit 3 serves as the reset input, its pull-up is forced on and it stops taking part in wake detection. The wake flag reports a change on the enabled pins since the last port read.

Top module: `gpio_port`

## Requirements
- R1: After reset every direction bit is 1, so `pad_oe` is all zeros. `pad_out`, `cpu_rdata`, `pull_en` and `wake_flag` are also zero.
- R2: A read (`cpu_op`=2) loads `cpu_rdata` at the next edge with the pad levels, whatever the direction bits are. Bits 7:6 always read 0.
- R3: A direction load (`dir_load`=1) takes bits 5:0 of `dir_wdata` at the next edge. After that, `pad_oe[i]` is the inverse of direction bit i, and `pad_out` carries the latch.
- R4: Bit 3 is input only: `pad_oe[3]` is always 0, whatever value is loaded into direction bit 3.
- R5: A write (`cpu_op`=1) loads the latch from `cpu_wdata[5:0]` at the next edge. An idle cycle (`cpu_op`=0) or a read leaves the latch unchanged.
- R6: A pin whose `alt_mask` bit is 1 reads as 0, both in `cpu_rdata` and in the value that set and clear write back.
- R7: Bit set (`cpu_op`=3) and bit clear (`cpu_op`=4) load the latch with the masked pad levels, with bit `cpu_bit` forced to 1 or to 0. This can change the latch bits of input pins.
- R8: `pull_en` bits 0, 1 and 3 all follow the single enable `wk_en`. The other bits are 0. The output is registered one cycle.
- R9: While `mclr_mode`=1, `pull_en[3]` is 1 from the next edge on, and a change on bit 3 does not set the wake flag.
- R10: With `wk_en`=1, `wake_flag` goes high at the edge after an enabled wake pin (0, 1, or 3 unless R9 excludes it) differs from the value captured at the last read. A change on any other pin does not set it. A read clears the flag and captures a new snapshot.
- R11: While `wk_en`=0, `wake_flag` is 0 from the next edge on, whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_op | input | 3 | 0 idle, 1 write, 2 read, 3 bit set, 4 bit clear |
| cpu_bit | input | 3 | Bit index for set and clear |
| cpu_wdata | input | 8 | Write data for the latch |
| cpu_rdata | output | 8 | Registered read data |
| dir_load | input | 1 | Direction load strobe |
| dir_wdata | input | 8 | Accumulator value for the direction bits |
| alt_mask | input | 6 | Pins owned by an alternate function |
| wk_en | input | 1 | Shared enable for pull-up and wake |
| mclr_mode | input | 1 | Bit 3 used as the reset input |
| pad_in | input | 6 | Pad input levels |
| pad_out | output | 6 | Pad output data |
| pad_oe | output | 6 | Pad output enable, high to drive |
| pull_en | output | 6 | Weak pull-up enables |
| wake_flag | output | 1 | Wake-on-change flag |

## Verification
The bench builds the port with its default parameters: an 8-bit port, six pins, bit 3 as the input-only pin and wake mask 6'b001011. The unimplemented bits 7:6 are therefore within reach, so reads can show that they stay zero. Because the input-only pin is also a wake pin, the interaction between reset-pin mode and pin 3 can be exercised. Set and clear are driven with pad levels that differ from the latch, including pins under alternate function, so the read-modify-write hazard shows up in `pad_out`.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    PORT_IDLE  = 3'd0,
    PORT_WRITE = 3'd1,
    PORT_READ  = 3'd2,
    PORT_BSET  = 3'd3,
    PORT_BCLR  = 3'd4
  } port_op_e;
endpackage

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
  parameter int PIN_W       = 6,
  parameter int IN_ONLY_BIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PIN_W-1:0] wdata,
  output logic [PIN_W-1:0] dir_q
);
  for (genvar i = 0; i < PIN_W; i++) begin : g_bit
    if (i == IN_ONLY_BIT) begin : g_fixed
      assign dir_q[i] = 1'b1;
    end else begin : g_reg
      logic d_q;
      always_ff @(posedge clk) begin
        if (rst)       d_q <= 1'b1;
        else if (load) d_q <= wdata[i];
      end
      assign dir_q[i] = d_q;
    end
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_pkg::*;
#(
  parameter int PIN_W = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  port_op_e         op,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic [PIN_W-1:0] wdata,
  input  logic [PIN_W-1:0] pin_view,
  output logic [PIN_W-1:0] latch_q
);
  logic [PIN_W-1:0] rmw_v;
  logic             set_val;

  assign set_val = (op == PORT_BSET);

  always_comb begin
    for (int i = 0; i < PIN_W; i++) begin
      rmw_v[i] = (bit_idx == IDX_W'(i)) ? set_val : pin_view[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
    end else begin
      case (op)
        PORT_WRITE:           latch_q <= wdata;
        PORT_BSET, PORT_BCLR: latch_q <= rmw_v;
        default:              latch_q <= latch_q;
      endcase
    end
  end
endmodule

// File: rtl/gpio_wake_unit.sv
module gpio_wake_unit #(
  parameter int             PIN_W       = 6,
  parameter int             IN_ONLY_BIT = 3,
  parameter logic [PIN_W-1:0] WAKE_MASK = 6'b001011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wk_en,
  input  logic             mclr_mode,
  input  logic             rd_strobe,
  input  logic [PIN_W-1:0] pad_in,
  output logic [PIN_W-1:0] pull_q,
  output logic             wake_q
);
  localparam logic [PIN_W-1:0] RST_PIN = PIN_W'(1) << IN_ONLY_BIT;

  logic [PIN_W-1:0] snap_q;
  logic [PIN_W-1:0] live_mask;
  logic [PIN_W-1:0] pull_d;
  logic             changed;

  assign live_mask = mclr_mode ? (WAKE_MASK & ~RST_PIN) : WAKE_MASK;
  assign changed   = |((pad_in ^ snap_q) & live_mask);
  assign pull_d    = (wk_en ? WAKE_MASK : '0) | (mclr_mode ? RST_PIN : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      wake_q <= 1'b0;
      pull_q <= '0;
    end else begin
      pull_q <= pull_d;
      if (rd_strobe) snap_q <= pad_in & WAKE_MASK;
      if (rd_strobe || !wk_en) wake_q <= 1'b0;
      else if (changed)        wake_q <= 1'b1;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int PIN_W       = 6,
  parameter int IN_ONLY_BIT = 3,
  parameter logic [PIN_W-1:0] WAKE_MASK = 6'b001011,
  localparam int IDX_W      = $clog2(PORT_W),
  localparam int PAD_W      = PORT_W - PIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cpu_op,
  input  logic [IDX_W-1:0]  cpu_bit,
  input  logic [PORT_W-1:0] cpu_wdata,
  output logic [PORT_W-1:0] cpu_rdata,
  input  logic              dir_load,
  input  logic [PORT_W-1:0] dir_wdata,
  input  logic [PIN_W-1:0]  alt_mask,
  input  logic              wk_en,
  input  logic              mclr_mode,
  input  logic [PIN_W-1:0]  pad_in,
  output logic [PIN_W-1:0]  pad_out,
  output logic [PIN_W-1:0]  pad_oe,
  output logic [PIN_W-1:0]  pull_en,
  output logic              wake_flag
);
  port_op_e         op;
  logic [PIN_W-1:0] pin_view;
  logic [PIN_W-1:0] dir_q;
  logic             rd_strobe;

  assign op        = port_op_e'(cpu_op);
  assign pin_view  = pad_in & ~alt_mask;
  assign rd_strobe = (op == PORT_READ);

  gpio_dir_reg #(.PIN_W(PIN_W), .IN_ONLY_BIT(IN_ONLY_BIT)) u_dir (
    .clk(clk), .rst(rst), .load(dir_load),
    .wdata(dir_wdata[PIN_W-1:0]), .dir_q(dir_q)
  );

  gpio_out_latch #(.PIN_W(PIN_W), .IDX_W(IDX_W)) u_latch (
    .clk(clk), .rst(rst), .op(op), .bit_idx(cpu_bit),
    .wdata(cpu_wdata[PIN_W-1:0]), .pin_view(pin_view), .latch_q(pad_out)
  );

  gpio_wake_unit #(.PIN_W(PIN_W), .IN_ONLY_BIT(IN_ONLY_BIT), .WAKE_MASK(WAKE_MASK)) u_wake (
    .clk(clk), .rst(rst), .wk_en(wk_en), .mclr_mode(mclr_mode),
    .rd_strobe(rd_strobe), .pad_in(pad_in), .pull_q(pull_en), .wake_q(wake_flag)
  );

  assign pad_oe = ~dir_q;

  always_ff @(posedge clk) begin
    if (rst)            cpu_rdata <= '0;
    else if (rd_strobe) cpu_rdata <= {{PAD_W{1'b0}}, pin_view};
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int PORT_W      = 8,
  parameter int PIN_W       = 6,
  parameter int IN_ONLY_BIT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        cpu_op,
  input logic [PORT_W-1:0] cpu_rdata,
  input logic              dir_load,
  input logic [PORT_W-1:0] dir_wdata,
  input logic              wk_en,
  input logic              mclr_mode,
  input logic [PIN_W-1:0]  pad_out,
  input logic [PIN_W-1:0]  pad_oe,
  input logic [PIN_W-1:0]  pull_en,
  input logic              wake_flag
);
  // R4
  in_only_pin_chk: assert property (@(posedge clk) disable iff (rst) !pad_oe[IN_ONLY_BIT]);

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst) cpu_rdata[PORT_W-1:PIN_W] == '0);

  // R3
  dir_apply_chk: assert property (@(posedge clk) disable iff (rst)
    dir_load |=> pad_oe[IN_ONLY_BIT-1:0] == ~$past(dir_wdata[IN_ONLY_BIT-1:0]));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_op == 3'd0 || cpu_op == 3'd2) |=> $stable(pad_out));

  // R9
  mclr_pull_chk: assert property (@(posedge clk) disable iff (rst) mclr_mode |=> pull_en[IN_ONLY_BIT]);

  // R10
  wake_clear_chk: assert property (@(posedge clk) disable iff (rst) cpu_op == 3'd2 |=> !wake_flag);

  // R11
  wake_off_chk: assert property (@(posedge clk) disable iff (rst) !wk_en |=> !wake_flag);
endmodule

bind gpio_port gpio_port_chk #(.PORT_W(PORT_W), .PIN_W(PIN_W), .IN_ONLY_BIT(IN_ONLY_BIT)) u_chk (
  .clk(clk), .rst(rst), .cpu_op(cpu_op), .cpu_rdata(cpu_rdata),
  .dir_load(dir_load), .dir_wdata(dir_wdata), .wk_en(wk_en), .mclr_mode(mclr_mode),
  .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en), .wake_flag(wake_flag)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cpu_op = 3'd0;
  logic [2:0] cpu_bit = 3'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic       dir_load = 1'b0;
  logic [7:0] dir_wdata = 8'd0;
  logic [5:0] alt_mask = 6'd0;
  logic       wk_en = 1'b0;
  logic       mclr_mode = 1'b0;
  logic [5:0] pad_in = 6'd0;
  logic [5:0] pad_out, pad_oe, pull_en;
  logic       wake_flag;

  typedef struct { string req; int sel; logic [7:0] exp; } item_t;
  item_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst(rst), .cpu_op(cpu_op), .cpu_bit(cpu_bit), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .dir_load(dir_load), .dir_wdata(dir_wdata), .alt_mask(alt_mask),
    .wk_en(wk_en), .mclr_mode(mclr_mode), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pull_en(pull_en), .wake_flag(wake_flag)
  );

  function automatic logic [7:0] observe(int sel);
    case (sel)
      0: return cpu_rdata;
      1: return {2'b00, pad_out};
      2: return {2'b00, pad_oe};
      3: return {2'b00, pull_en};
      default: return {7'd0, wake_flag};
    endcase
  endfunction

  // Scoreboard monitor: compares at falling edges, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (observe(it.sel) !== it.exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, observe(it.sel), it.exp);
        end
      end
    end
  end

  task automatic expect_out(string req, int sel, logic [7:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
  endtask

  // Drive at a falling edge, let one rising edge act, then return
  task automatic step(logic [2:0] op, logic [2:0] b, logic [7:0] wd);
    @(negedge clk);
    cpu_op = op; cpu_bit = b; cpu_wdata = wd;
    @(posedge clk);
    #1;
    @(negedge clk);
    cpu_op = 3'd0; dir_load = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    // R1 reset state
    expect_out("R1", 0, 8'h00); expect_out("R1", 1, 8'h00); expect_out("R1", 2, 8'h00);
    expect_out("R1", 3, 8'h00); expect_out("R1", 4, 8'h00);

    step(3'd1, 3'd0, 8'hEA);              // R5 write, upper bits dropped
    expect_out("R5", 1, 8'h2A);
    expect_out("R3", 2, 8'h00);           // R3 all still inputs
    @(negedge clk) begin dir_load = 1'b1; dir_wdata = 8'h00; end
    step(3'd0, 3'd0, 8'h00);
    expect_out("R4", 2, 8'h37);           // R3 R4 bit 3 stays off
    expect_out("R3", 1, 8'h2A);

    @(negedge clk) pad_in = 6'h15;
    step(3'd2, 3'd0, 8'h00);
    expect_out("R2", 0, 8'h15);
    @(negedge clk) pad_in = 6'h3F;
    step(3'd2, 3'd0, 8'h00);
    expect_out("R2", 0, 8'h3F);
    @(negedge clk) alt_mask = 6'b000011;
    step(3'd2, 3'd0, 8'h00);
    expect_out("R6", 0, 8'h3C);
    @(negedge clk) alt_mask = 6'd0;
    step(3'd0, 3'd0, 8'h00);
    step(3'd2, 3'd0, 8'h00);
    expect_out("R5", 1, 8'h2A);           // latch held over idle and read

    @(negedge clk) pad_in = 6'h05;
    step(3'd3, 3'd4, 8'h00);
    expect_out("R7", 1, 8'h15);
    step(3'd4, 3'd0, 8'h00);
    expect_out("R7", 1, 8'h04);
    @(negedge clk) alt_mask = 6'b000100;
    step(3'd3, 3'd5, 8'h00);
    expect_out("R6", 1, 8'h21);           // R6 R7 alternate pin written back as 0
    @(negedge clk) alt_mask = 6'd0;

    @(negedge clk) begin dir_load = 1'b1; dir_wdata = 8'hFF; end
    step(3'd0, 3'd0, 8'h00);
    expect_out("R3", 2, 8'h00);

    @(negedge clk) wk_en = 1'b1;
    step(3'd0, 3'd0, 8'h00);
    expect_out("R8", 3, 8'h0B);
    @(negedge clk) begin wk_en = 1'b0; mclr_mode = 1'b1; end
    step(3'd0, 3'd0, 8'h00);
    expect_out("R9", 3, 8'h08);
    @(negedge clk) mclr_mode = 1'b0;
    step(3'd0, 3'd0, 8'h00);
    expect_out("R8", 3, 8'h00);

    @(negedge clk) begin wk_en = 1'b1; pad_in = 6'h00; end
    step(3'd2, 3'd0, 8'h00);
    expect_out("R10", 4, 8'h00);
    @(negedge clk) pad_in = 6'h04;
    step(3'd0, 3'd0, 8'h00);
    expect_out("R10", 4, 8'h00);          // pin 2 is not a wake pin
    @(negedge clk) pad_in = 6'h0C;
    step(3'd0, 3'd0, 8'h00);
    expect_out("R10", 4, 8'h01);
    step(3'd2, 3'd0, 8'h00);
    expect_out("R10", 4, 8'h00);
    step(3'd0, 3'd0, 8'h00);
    expect_out("R10", 4, 8'h00);          // new snapshot matches

    @(negedge clk) mclr_mode = 1'b1;
    @(negedge clk) pad_in = 6'h04;
    step(3'd0, 3'd0, 8'h00);
    expect_out("R9", 4, 8'h00);
    @(negedge clk) pad_in = 6'h05;
    step(3'd0, 3'd0, 8'h00);
    expect_out("R10", 4, 8'h01);
    @(negedge clk) wk_en = 1'b0;
    step(3'd0, 3'd0, 8'h00);
    expect_out("R11", 4, 8'h00);
    @(negedge clk) pad_in = 6'h06;
    step(3'd0, 3'd0, 8'h00);
    expect_out("R11", 4, 8'h00);

    repeat (3) @(posedge clk);
    done = 1;
    finish_run();
  end
endmodule